// File: doc/BRIEF.md
# Serial EEPROM Configuration-Space Bridge

This block lets host software bit-bang a three-wire serial EEPROM (chip select, shift clock, serial data in, serial data out) through configuration-space accesses alone. There is no dedicated control register. A configuration write to one offset selects the device and sets the shift clock and data-in levels from two bits of the written byte. A write to a second offset drops all three lines. Writes to any other offset go on to ordinary configuration storage. Software reads the EEPROM's data-out line indirectly. A single-byte configuration read of offset 0x00 returns the normal byte when data-out is high and returns zero when it is low.

After reset, a checksum engine walks a default 128-byte EEPROM image, one 16-bit little-endian word per clock. It sums words 0 to 62 (bytes 0 to 125). It then fills the last word with a seed minus that sum, so the words of the finished image add up to the seed. The finished image can be read byte by byte, for example to load the EEPROM model.

Top module: `ee_cfg_bridge`

## Requirements
- R1: A configuration write to offset 0x80 sets `ee_cs` to 1, `ee_sk` to bit 7 of the written byte (`cfg_wbits[1]`) and `ee_di` to bit 6 (`cfg_wbits[0]`), all visible one clock after the write cycle.
- R2: A configuration write to offset 0xC0 drives `ee_cs`, `ee_sk` and `ee_di` to 0 one clock after the write cycle.
- R3: A write to any other offset, or a cycle with no write, leaves the three EEPROM pins unchanged. `cfg_pt_wr_en` is high in exactly those write cycles whose offset is neither 0x80 nor 0xC0.
- R4: While `rst_n` is sampled low, the pins are 0 and `csum_done` is 0.
- R5: `cfg_rdata` equals `cfg_std_rdata` with bits 7:0 forced to 0 when `cfg_rd_bytes` is 1, `cfg_addr` is 0x00 and `ee_do` is 0. In every other case it equals `cfg_std_rdata` unchanged.
- R6: The default image holds 0x57 at each even byte 0..30 and 0x00 at each odd byte 1..31. It holds 0x07 at byte 64, 0x0F at byte 65, 0x04 at byte 67 and 0x07 at byte 68. Every other byte below 126 is 0x00.
- R7: Once `csum_done` is high, image bytes 126 (low) and 127 (high) hold 0x1234 minus the 16-bit sum of the little-endian words at bytes 0, 2, …, 124. With the default image this is 0xF9B6.
- R8: `csum_done` rises after exactly 63 clocks with reset released and then stays high. Before that, image bytes 126 and 127 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset (read and write) |
| cfg_wbits | input | 2 | Bits 7 and 6 of the written byte |
| cfg_rd_bytes | input | 3 | Read size in bytes (1, 2 or 4) |
| cfg_std_rdata | input | 32 | Read data from normal configuration storage |
| cfg_rdata | output | 32 | Read data returned to the host |
| cfg_pt_wr_en | output | 1 | Write forwarded to normal configuration storage |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM shift clock |
| ee_di | output | 1 | EEPROM serial data in |
| ee_do | input | 1 | EEPROM serial data out |
| img_addr | input | 7 | Image byte address |
| img_data | output | 8 | Image byte at `img_addr` |
| csum_done | output | 1 | Checksum word is filled in |

## Verification
The bench builds the bridge with its default parameters: an 8-bit offset, a 32-bit read word and a 128-byte image. These sizes are small enough that every one of the 256 offsets is written with all four combinations of the two pin bits, and every image byte is read back. The read mask is swept over low offsets, all three access sizes and both data-out levels. The 63-word walk is short enough to be timed exactly, clock by clock, both after the initial reset and after a reset issued mid-run.

// File: rtl/ee_bridge_pkg.sv
// Shared types and default-image contents for the serial EEPROM bridge.
// Assumes byte positions of the adapter fields are fixed by the image format.
package ee_bridge_pkg;

    typedef struct packed {
        logic cs;
        logic sk;
        logic di;
    } ee_pins_t;

    // Byte positions decoded by the consumer of the image
    localparam int unsigned POS_ID   = 64;
    localparam int unsigned POS_MODE = 65;
    localparam int unsigned POS_TAG  = 67;
    localparam int unsigned POS_OPT  = 68;

    // Default content of one image byte (checksum bytes excluded)
    function automatic logic [7:0] dflt_byte(
        input int unsigned b,
        input logic [7:0]  fill,
        input int unsigned pairs,
        input logic [7:0]  id_v,
        input logic [7:0]  mode_v,
        input logic [7:0]  tag_v,
        input logic [7:0]  opt_v
    );
        logic [7:0] v;
        v = 8'h00;
        if (b < 2 * pairs) begin
            v = (b % 2 == 0) ? fill : 8'h00;
        end else if (b == POS_ID) begin
            v = id_v;
        end else if (b == POS_MODE) begin
            v = mode_v;
        end else if (b == POS_TAG) begin
            v = tag_v;
        end else if (b == POS_OPT) begin
            v = opt_v;
        end
        return v;
    endfunction

endpackage

// File: rtl/ee_pin_ctrl.sv
// Decodes configuration writes into registered EEPROM pin levels.
// Assumes one write per strobe cycle; the pins change only on a hit.
module ee_pin_ctrl
    import ee_bridge_pkg::*;
#(
    parameter int unsigned    CFG_AW    = 8,
    parameter logic [CFG_AW-1:0] SEL_OFS   = 8'h80,
    parameter logic [CFG_AW-1:0] DESEL_OFS = 8'hC0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CFG_AW-1:0] addr,
    input  logic [1:0]        wbits,
    output ee_pins_t          pins,
    output logic              pt_wr_en
);

    logic hit_sel;
    logic hit_desel;
    ee_pins_t pins_q;

    // Offset decode for the two pin-control offsets
    always_comb begin
        hit_sel   = (addr == SEL_OFS);
        hit_desel = (addr == DESEL_OFS);
    end

    // Forward every other write to normal configuration storage
    always_comb pt_wr_en = wr_en && !hit_sel && !hit_desel;

    // Pin register: one update per decoded write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pins_q <= '0;
        end else if (wr_en && hit_sel) begin
            pins_q <= '{cs: 1'b1, sk: wbits[1], di: wbits[0]};
        end else if (wr_en && hit_desel) begin
            pins_q <= '0;
        end
    end

    assign pins = pins_q;

endmodule

// File: rtl/ee_do_mask.sv
// Folds the EEPROM data-out line into one configuration read byte.
// Assumes the read path is combinational from the storage read data.
module ee_do_mask #(
    parameter int unsigned       CFG_AW   = 8,
    parameter int unsigned       CFG_DW   = 32,
    parameter logic [CFG_AW-1:0] MASK_OFS = 8'h00
) (
    input  logic [CFG_AW-1:0] addr,
    input  logic [2:0]        rd_bytes,
    input  logic              ee_do,
    input  logic [CFG_DW-1:0] std_rdata,
    output logic [CFG_DW-1:0] rdata
);

    logic clear_lo;

    // A single-byte read of the mask offset with data-out low clears the byte
    always_comb clear_lo = (rd_bytes == 3'd1) && (addr == MASK_OFS) && !ee_do;

    // Return storage data, low byte cleared when required
    always_comb begin
        rdata = std_rdata;
        if (clear_lo) begin
            rdata[7:0] = 8'h00;
        end
    end

endmodule

// File: rtl/ee_image_rom.sv
// Computed default EEPROM image with a byte port and a 16-bit word port.
// Assumes the checksum bytes are overlaid outside this module.
module ee_image_rom
    import ee_bridge_pkg::*;
#(
    parameter int unsigned IMG_AW     = 7,
    parameter logic [7:0]  FILL_BYTE  = 8'h57,
    parameter int unsigned FILL_PAIRS = 16,
    parameter logic [7:0]  ID_BYTE    = 8'h07,
    parameter logic [7:0]  MODE_BYTE  = 8'h0F,
    parameter logic [7:0]  TAG_BYTE   = 8'h04,
    parameter logic [7:0]  OPT_BYTE   = 8'h07
) (
    input  logic [IMG_AW-1:0] byte_addr,
    input  logic [IMG_AW-2:0] word_idx,
    output logic [7:0]        byte_data,
    output logic [15:0]       word_data
);

    // Byte port lookup
    always_comb byte_data = dflt_byte(int'(byte_addr), FILL_BYTE, FILL_PAIRS,
                                      ID_BYTE, MODE_BYTE, TAG_BYTE, OPT_BYTE);

    // Word port: one lane per byte, little-endian order
    for (genvar ln = 0; ln < 2; ln++) begin : g_lane
        logic [IMG_AW-1:0] lane_addr;
        always_comb lane_addr = {word_idx, ln[0]};
        always_comb word_data[8*ln +: 8] = dflt_byte(int'(lane_addr), FILL_BYTE, FILL_PAIRS,
                                                    ID_BYTE, MODE_BYTE, TAG_BYTE, OPT_BYTE);
    end

endmodule

// File: rtl/ee_csum_engine.sv
// Walks the image words once after reset and forms seed minus word sum.
// Assumes the word port answers in the same cycle as the index.
module ee_csum_engine #(
    parameter int unsigned IMG_AW = 7,
    parameter logic [15:0] SEED   = 16'h1234
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       word_data,
    output logic [IMG_AW-2:0] word_idx,
    output logic              done,
    output logic [15:0]       csum
);

    localparam int unsigned WORDS = (2 ** IMG_AW - 2) / 2;
    localparam logic [IMG_AW-2:0] LAST = (IMG_AW-1)'(WORDS - 1);

    logic [IMG_AW-2:0] idx_q;
    logic [15:0]       sum_q;
    logic              done_q;

    // Accumulate one word per clock until the last data word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            sum_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            sum_q <= sum_q + word_data;
            if (idx_q == LAST) begin
                done_q <= 1'b1;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Checksum word makes all words add up to the seed
    always_comb csum = SEED - sum_q;

    assign word_idx = idx_q;
    assign done     = done_q;

endmodule

// File: rtl/ee_cfg_bridge.sv
// Top: configuration-space bridge to a bit-banged serial EEPROM, plus
// the default-image checksum filler. Assumes one config access per cycle.
module ee_cfg_bridge
    import ee_bridge_pkg::*;
#(
    parameter int unsigned       CFG_AW     = 8,
    parameter int unsigned       CFG_DW     = 32,
    parameter logic [CFG_AW-1:0] SEL_OFS    = 8'h80,
    parameter logic [CFG_AW-1:0] DESEL_OFS  = 8'hC0,
    parameter logic [CFG_AW-1:0] MASK_OFS   = 8'h00,
    parameter int unsigned       IMG_AW     = 7,
    parameter logic [7:0]        FILL_BYTE  = 8'h57,
    parameter int unsigned       FILL_PAIRS = 16,
    parameter logic [7:0]        ID_BYTE    = 8'h07,
    parameter logic [7:0]        MODE_BYTE  = 8'h0F,
    parameter logic [7:0]        TAG_BYTE   = 8'h04,
    parameter logic [7:0]        OPT_BYTE   = 8'h07,
    parameter logic [15:0]       SEED       = 16'h1234
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [1:0]        cfg_wbits,
    input  logic [2:0]        cfg_rd_bytes,
    input  logic [CFG_DW-1:0] cfg_std_rdata,
    output logic [CFG_DW-1:0] cfg_rdata,
    output logic              cfg_pt_wr_en,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do,
    input  logic [IMG_AW-1:0] img_addr,
    output logic [7:0]        img_data,
    output logic              csum_done
);

    localparam int unsigned IMG_BYTES = 2 ** IMG_AW;
    localparam logic [IMG_AW-1:0] CS_LO = IMG_AW'(IMG_BYTES - 2);
    localparam logic [IMG_AW-1:0] CS_HI = IMG_AW'(IMG_BYTES - 1);

    ee_pins_t          pins;
    logic [7:0]        rom_byte;
    logic [15:0]       rom_word;
    logic [IMG_AW-2:0] walk_idx;
    logic [15:0]       csum;
    logic              done;

    ee_pin_ctrl #(
        .CFG_AW(CFG_AW), .SEL_OFS(SEL_OFS), .DESEL_OFS(DESEL_OFS)
    ) u_pins (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .addr(cfg_addr),
        .wbits(cfg_wbits), .pins(pins), .pt_wr_en(cfg_pt_wr_en)
    );

    ee_do_mask #(
        .CFG_AW(CFG_AW), .CFG_DW(CFG_DW), .MASK_OFS(MASK_OFS)
    ) u_mask (
        .addr(cfg_addr), .rd_bytes(cfg_rd_bytes), .ee_do(ee_do),
        .std_rdata(cfg_std_rdata), .rdata(cfg_rdata)
    );

    ee_image_rom #(
        .IMG_AW(IMG_AW), .FILL_BYTE(FILL_BYTE), .FILL_PAIRS(FILL_PAIRS),
        .ID_BYTE(ID_BYTE), .MODE_BYTE(MODE_BYTE), .TAG_BYTE(TAG_BYTE),
        .OPT_BYTE(OPT_BYTE)
    ) u_rom (
        .byte_addr(img_addr), .word_idx(walk_idx),
        .byte_data(rom_byte), .word_data(rom_word)
    );

    ee_csum_engine #(
        .IMG_AW(IMG_AW), .SEED(SEED)
    ) u_csum (
        .clk(clk), .rst_n(rst_n), .word_data(rom_word),
        .word_idx(walk_idx), .done(done), .csum(csum)
    );

    // Overlay the checksum word on the last two image bytes
    always_comb begin
        if (img_addr == CS_LO) begin
            img_data = done ? csum[7:0] : 8'h00;
        end else if (img_addr == CS_HI) begin
            img_data = done ? csum[15:8] : 8'h00;
        end else begin
            img_data = rom_byte;
        end
    end

    // Expose pin register and completion flag
    always_comb begin
        ee_cs     = pins.cs;
        ee_sk     = pins.sk;
        ee_di     = pins.di;
        csum_done = done;
    end

endmodule

// File: rtl/ee_cfg_bridge_chk.sv
// Checker for ee_cfg_bridge; observes top-level ports only.
module ee_cfg_bridge_chk #(
    parameter int unsigned       CFG_AW    = 8,
    parameter int unsigned       CFG_DW    = 32,
    parameter logic [CFG_AW-1:0] SEL_OFS   = 8'h80,
    parameter logic [CFG_AW-1:0] DESEL_OFS = 8'hC0,
    parameter logic [CFG_AW-1:0] MASK_OFS  = 8'h00,
    parameter int unsigned       IMG_AW    = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic [1:0]        cfg_wbits,
    input logic [2:0]        cfg_rd_bytes,
    input logic [CFG_DW-1:0] cfg_std_rdata,
    input logic [CFG_DW-1:0] cfg_rdata,
    input logic              cfg_pt_wr_en,
    input logic              ee_cs,
    input logic              ee_sk,
    input logic              ee_di,
    input logic              ee_do,
    input logic [IMG_AW-1:0] img_addr,
    input logic [7:0]        img_data,
    input logic              csum_done
);

    localparam int unsigned WORDS = (2 ** IMG_AW - 2) / 2;
    localparam int unsigned CW    = $clog2(WORDS + 1) + 1;
    localparam logic [IMG_AW-1:0] CS_LO = IMG_AW'(2 ** IMG_AW - 2);

    logic [CW-1:0] run_cnt;
    logic          pin_hit;

    // Count active clocks since reset, saturating at the walk length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (run_cnt != CW'(WORDS)) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    always_comb pin_hit = cfg_wr_en && (cfg_addr == SEL_OFS || cfg_addr == DESEL_OFS);

    AST_SEL_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_addr == SEL_OFS) |=>
        (ee_cs && ee_sk == $past(cfg_wbits[1]) && ee_di == $past(cfg_wbits[0]))); // R1

    AST_DESEL_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_addr == DESEL_OFS) |=> (!ee_cs && !ee_sk && !ee_di)); // R2

    AST_PINS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_hit |=> $stable({ee_cs, ee_sk, ee_di})); // R3

    AST_PT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_pt_wr_en |-> (cfg_wr_en && !pin_hit)); // R3

    AST_DO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_bytes == 3'd1 && cfg_addr == MASK_OFS && !ee_do) |->
        (cfg_rdata[7:0] == 8'h00 && cfg_rdata[CFG_DW-1:8] == cfg_std_rdata[CFG_DW-1:8])); // R5

    AST_DO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ee_do |-> (cfg_rdata == cfg_std_rdata)); // R5

    AST_DONE_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        csum_done == (run_cnt == CW'(WORDS))); // R8

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        csum_done |=> csum_done); // R8

    AST_CSUM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!csum_done && img_addr[IMG_AW-1:1] == CS_LO[IMG_AW-1:1]) |-> (img_data == 8'h00)); // R8

endmodule

bind ee_cfg_bridge ee_cfg_bridge_chk #(
    .CFG_AW(CFG_AW), .CFG_DW(CFG_DW), .SEL_OFS(SEL_OFS), .DESEL_OFS(DESEL_OFS),
    .MASK_OFS(MASK_OFS), .IMG_AW(IMG_AW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wbits(cfg_wbits), .cfg_rd_bytes(cfg_rd_bytes), .cfg_std_rdata(cfg_std_rdata),
    .cfg_rdata(cfg_rdata), .cfg_pt_wr_en(cfg_pt_wr_en), .ee_cs(ee_cs), .ee_sk(ee_sk),
    .ee_di(ee_di), .ee_do(ee_do), .img_addr(img_addr), .img_data(img_data),
    .csum_done(csum_done)
);

// File: tb/sim_ee_cfg_bridge.sv
module sim_ee_cfg_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [1:0]  cfg_wbits = 2'b00;
    logic [2:0]  cfg_rd_bytes = 3'd4;
    logic [31:0] cfg_std_rdata = 32'h0;
    logic [31:0] cfg_rdata;
    logic        cfg_pt_wr_en;
    logic        ee_cs, ee_sk, ee_di;
    logic        ee_do = 1'b1;
    logic [6:0]  img_addr = 7'd0;
    logic [7:0]  img_data;
    logic        csum_done;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [2:0] exp_pins;
    logic [7:0] exp_img [128];

    always #2 clk = ~clk;

    ee_cfg_bridge u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wbits(cfg_wbits), .cfg_rd_bytes(cfg_rd_bytes), .cfg_std_rdata(cfg_std_rdata),
        .cfg_rdata(cfg_rdata), .cfg_pt_wr_en(cfg_pt_wr_en), .ee_cs(ee_cs), .ee_sk(ee_sk),
        .ee_di(ee_di), .ee_do(ee_do), .img_addr(img_addr), .img_data(img_data),
        .csum_done(csum_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reset, then time the checksum walk (R4, R8)
    task automatic reset_and_walk();
        @(negedge clk);
        rst_n = 1'b0;
        cfg_wr_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R4 pins in reset", {29'd0, ee_cs, ee_sk, ee_di}, 32'd0);
        chk("R4 done in reset", {31'd0, csum_done}, 32'd0);
        exp_pins = 3'b000;
        rst_n = 1'b1;
        img_addr = 7'd126;
        #1 chk("R8 low csum byte busy", {24'd0, img_data}, 32'd0);
        img_addr = 7'd127;
        #1 chk("R8 high csum byte busy", {24'd0, img_data}, 32'd0);
        repeat (62) @(negedge clk);
        chk("R8 done after 62 clocks", {31'd0, csum_done}, 32'd0);
        @(negedge clk);
        chk("R8 done after 63 clocks", {31'd0, csum_done}, 32'd1);
        repeat (5) @(negedge clk);
        chk("R8 done stays high", {31'd0, csum_done}, 32'd1);
    endtask

    initial begin
        logic [15:0] sum;
        logic [15:0] cs;
        logic [31:0] pat;
        logic [31:0] expd;

        // Expected image built from the requirement text (R6, R7)
        for (int b = 0; b < 128; b++) begin
            exp_img[b] = 8'h00;
            if (b < 32 && b % 2 == 0) exp_img[b] = 8'h57;
        end
        exp_img[64] = 8'h07;
        exp_img[65] = 8'h0F;
        exp_img[67] = 8'h04;
        exp_img[68] = 8'h07;
        sum = 16'h0;
        for (int w = 0; w < 63; w++) sum = sum + {exp_img[2*w+1], exp_img[2*w]};
        cs = 16'h1234 - sum;
        exp_img[126] = cs[7:0];
        exp_img[127] = cs[15:8];

        reset_and_walk();
        chk("R7 default checksum value", {16'd0, cs}, 32'h0000F9B6);

        // Image readback sweep (R6, R7)
        for (int b = 0; b < 128; b++) begin
            img_addr = 7'(b);
            #1;
            if (b >= 126) chk("R7 checksum byte", {24'd0, img_data}, {24'd0, exp_img[b]});
            else          chk("R6 image byte", {24'd0, img_data}, {24'd0, exp_img[b]});
        end

        // Write sweep: every offset, every pin bit combination (R1, R2, R3)
        for (int d = 0; d < 4; d++) begin
            for (int a = 0; a < 256; a++) begin
                @(negedge clk);
                cfg_wr_en = 1'b1;
                cfg_addr  = 8'(a);
                cfg_wbits = 2'((a + d) % 4);
                #1;
                chk("R3 pass-through strobe", {31'd0, cfg_pt_wr_en},
                    {31'd0, (a != 8'h80 && a != 8'hC0)});
                if (a == 8'h80)      exp_pins = {1'b1, cfg_wbits};
                else if (a == 8'hC0) exp_pins = 3'b000;
                @(posedge clk);
                #1;
                if (a == 8'h80)      chk("R1 select write", {29'd0, ee_cs, ee_sk, ee_di}, {29'd0, exp_pins});
                else if (a == 8'hC0) chk("R2 deselect write", {29'd0, ee_cs, ee_sk, ee_di}, {29'd0, exp_pins});
                else                 chk("R3 other write holds", {29'd0, ee_cs, ee_sk, ee_di}, {29'd0, exp_pins});
            end
        end

        // Idle cycles leave the pins alone (R3)
        @(negedge clk);
        cfg_addr = 8'h80;
        cfg_wbits = 2'b11;
        exp_pins = 3'b111;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        cfg_addr = 8'hC0;
        repeat (3) @(negedge clk);
        chk("R3 idle holds pins", {29'd0, ee_cs, ee_sk, ee_di}, {29'd0, exp_pins});
        #1 chk("R3 no strobe when idle", {31'd0, cfg_pt_wr_en}, 32'd0);

        // Read mask sweep (R5)
        for (int a = 0; a < 8; a++) begin
            for (int s = 0; s < 3; s++) begin
                for (int dv = 0; dv < 2; dv++) begin
                    for (int p = 0; p < 2; p++) begin
                        pat = (p == 0) ? 32'hA5C3_7E19 : 32'hFFFF_FFFF;
                        cfg_addr = 8'(a);
                        cfg_rd_bytes = (s == 0) ? 3'd1 : (s == 1) ? 3'd2 : 3'd4;
                        ee_do = dv[0];
                        cfg_std_rdata = pat;
                        #1;
                        expd = (s == 0 && a == 0 && dv == 0) ? {pat[31:8], 8'h00} : pat;
                        chk("R5 read data", cfg_rdata, expd);
                    end
                end
            end
        end
        ee_do = 1'b1;

        // Reset mid-run with pins set, then the walk repeats (R4, R8)
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_addr = 8'h80;
        cfg_wbits = 2'b10;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        chk("R1 select before reset", {29'd0, ee_cs, ee_sk, ee_di}, 32'd6);
        reset_and_walk();
        img_addr = 7'd126;
        #1 chk("R7 low byte after rewalk", {24'd0, img_data}, {24'd0, exp_img[126]});
        img_addr = 7'd127;
        #1 chk("R7 high byte after rewalk", {24'd0, img_data}, {24'd0, exp_img[127]});

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule